// File: doc/BRIEF.md
# Station Address Hash Filter

This block decides whether an incoming frame is addressed to this station. Each frame's six destination-address bytes arrive one per cycle on a byte stream, first byte first. The block passes them through a bit-serial reflected CRC-32 and uses the top six bits of the CRC as an index into a 64-entry hash table. The table is held as two 32-bit words. At the same time the block compares the address against a programmed 48-bit station address.

A frame is accepted when either test hits. The verdict appears on a one-cycle valid pulse right after the sixth byte has been taken. A start-of-frame pulse aborts any partial address and starts a fresh one. The hash table and the station address are static inputs. The block samples them on the start-of-frame pulse, so the host may change them at any time and the change applies from the following frame on.

Top module: `addr_hash_filter`

## Requirements
- R1: After reset no verdict is produced, and address bytes that arrive before the first start-of-frame pulse are discarded without producing a verdict.
- R2: The hash index (`dec_index`) is bits 31:26 of a CRC-32. The CRC starts at 0xFFFFFFFF and takes the address bits least significant bit first, byte 0 first. For each bit it shifts right by one and XORs in 0xEDB88320 when the incoming bit differs from CRC bit 0.
- R3: An index from 32 to 63 selects bit (index-32) of `tbl_upper`. An index from 0 to 31 selects that bit of `tbl_lower`. The chosen bit is reported on `dec_hash`.
- R4: `dec_accept` is 1 when the exact compare hits or the selected hash bit is 1. It is 0 when neither hits and whenever `dec_valid` is 0.
- R5: The exact compare uses these fields:
  - `sta_upper[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` hold address bytes 0 to 3.
  - `sta_lower[31:24]` holds byte 4 and `sta_lower[23:16]` holds byte 5.
  - `sta_lower[15:0]` plays no part.
- R6: `dec_valid` is high for exactly one cycle. That cycle directly follows the clock edge on which the sixth byte is taken.
- R7: A start-of-frame pulse discards any partial address and reseeds the CRC. A byte presented in the same cycle as the pulse counts as byte 0 of the new frame.
- R8: Bytes after the sixth are ignored until the next start-of-frame pulse, and they produce no further verdict.
- R9: The table and station inputs are sampled on the start-of-frame pulse. Changing them mid-frame does not alter the current verdict; the change applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame pulse |
| byte_valid | input | 1 | Address byte present this cycle |
| byte_data | input | 8 | Address byte |
| tbl_upper | input | 32 | Hash table entries 32..63 |
| tbl_lower | input | 32 | Hash table entries 0..31 |
| sta_upper | input | 32 | Station address bytes 0..3 |
| sta_lower | input | 32 | Station address bytes 4..5 in the top half |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_exact | output | 1 | Exact station match |
| dec_hash | output | 1 | Selected hash bit |
| dec_index | output | 6 | Hash index of the frame |

## Verification
The verdict, with its accept, exact, hash and index fields, is due one cycle after the sixth byte is taken. Nothing is due one cycle after the fifth byte, and nothing is due two cycles after the sixth. The bench drives every byte on the falling edge. It samples the outputs on the falling edge that follows the consuming rising edge, and checks one falling edge before and one after for the pulse's absence. For ignored bytes (before the first start-of-frame pulse, and past the sixth byte), a pulse counter runs over a window several cycles longer than the one-cycle latency. Any stray verdict therefore shows up in the count.

// File: rtl/ahf_pkg.sv
package ahf_pkg;
    localparam int unsigned AHF_ADDR_BYTES = 6;
    localparam int unsigned AHF_CRC_W      = 32;
    localparam int unsigned AHF_IDX_W      = 6;
    localparam int unsigned AHF_WORD_W     = 32;
    localparam logic [31:0] AHF_POLY       = 32'hEDB88320;
    localparam logic [31:0] AHF_SEED       = 32'hFFFFFFFF;

    typedef struct packed {
        logic       valid;
        logic       accept;
        logic       exact;
        logic       hash;
        logic [AHF_IDX_W-1:0] index;
    } ahf_verdict_t;
endpackage

// File: rtl/ahf_crc_step.sv
module ahf_crc_step #(
    parameter int unsigned          CRC_W  = 32,
    parameter int unsigned          DATA_W = 8,
    parameter logic [CRC_W-1:0]     POLY   = 32'hEDB88320
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    // One stage per data bit, least significant bit consumed first.
    logic [CRC_W-1:0] stage [DATA_W+1];
    assign stage[0] = crc_in;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic fb;
        assign fb = data_in[b] ^ stage[b][0];
        assign stage[b+1] = (stage[b] >> 1) ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[DATA_W];
endmodule

// File: rtl/ahf_hash_lookup.sv
module ahf_hash_lookup #(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned WORD_W = 32
) (
    input  logic [IDX_W-1:0]  index,
    input  logic [WORD_W-1:0] tbl_hi,
    input  logic [WORD_W-1:0] tbl_lo,
    output logic              hit
);
    localparam int unsigned BIT_W = $clog2(WORD_W);

    logic              upper_sel;
    logic [BIT_W-1:0]  bit_sel;

    assign upper_sel = index[BIT_W];
    assign bit_sel   = index[BIT_W-1:0];
    assign hit       = upper_sel ? tbl_hi[bit_sel] : tbl_lo[bit_sel];
endmodule

// File: rtl/ahf_exact_match.sv
module ahf_exact_match #(
    parameter int unsigned ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] station,
    output logic              match
);
    assign match = (addr == station);
endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter
    import ahf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = AHF_ADDR_BYTES,
    parameter int unsigned CRC_W      = AHF_CRC_W,
    parameter int unsigned IDX_W      = AHF_IDX_W,
    parameter int unsigned WORD_W     = AHF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic [WORD_W-1:0] tbl_upper,
    input  logic [WORD_W-1:0] tbl_lower,
    input  logic [31:0]       sta_upper,
    input  logic [31:0]       sta_lower,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              dec_exact,
    output logic              dec_hash,
    output logic [IDX_W-1:0]  dec_index
);
    localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
    localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CRC_W-1:0]  crc;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] tbl_hi;
        logic [WORD_W-1:0] tbl_lo;
        logic [ADDR_W-1:0] sta;
        ahf_verdict_t      vd;
    } state_t;

    state_t st_d, st_q;

    // Frame-local view: a start pulse reseeds everything this same cycle.
    logic [CNT_W-1:0]  base_cnt;
    logic [CRC_W-1:0]  base_crc;
    logic [ADDR_W-1:0] base_addr;
    logic [WORD_W-1:0] cfg_hi, cfg_lo;
    logic [ADDR_W-1:0] cfg_sta;
    logic [ADDR_W-1:0] next_addr;
    logic [CRC_W-1:0]  step_crc;
    logic [IDX_W-1:0]  step_idx;
    logic              hash_hit, exact_hit;

    assign base_cnt  = sof ? '0 : st_q.cnt;
    assign base_crc  = sof ? CRC_W'(AHF_SEED) : st_q.crc;
    assign base_addr = sof ? '0 : st_q.addr;
    assign cfg_hi    = sof ? tbl_upper : st_q.tbl_hi;
    assign cfg_lo    = sof ? tbl_lower : st_q.tbl_lo;
    assign cfg_sta   = sof ? {sta_upper, sta_lower[31:16]} : st_q.sta;
    assign next_addr = {base_addr[ADDR_W-9:0], byte_data};
    assign step_idx  = step_crc[CRC_W-1 -: IDX_W];

    ahf_crc_step #(
        .CRC_W  (CRC_W),
        .DATA_W (8),
        .POLY   (CRC_W'(AHF_POLY))
    ) u_crc (
        .crc_in  (base_crc),
        .data_in (byte_data),
        .crc_out (step_crc)
    );

    ahf_hash_lookup #(
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) u_lookup (
        .index  (step_idx),
        .tbl_hi (cfg_hi),
        .tbl_lo (cfg_lo),
        .hit    (hash_hit)
    );

    ahf_exact_match #(
        .ADDR_W (ADDR_W)
    ) u_exact (
        .addr    (next_addr),
        .station (cfg_sta),
        .match   (exact_hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vd     = '0;
        st_d.cnt    = base_cnt;
        st_d.crc    = base_crc;
        st_d.addr   = base_addr;
        st_d.tbl_hi = cfg_hi;
        st_d.tbl_lo = cfg_lo;
        st_d.sta    = cfg_sta;
        if (byte_valid && (base_cnt < CNT_IDLE)) begin
            st_d.cnt  = base_cnt + 1'b1;
            st_d.crc  = step_crc;
            st_d.addr = next_addr;
            if (base_cnt == CNT_LAST) begin
                st_d.vd.valid  = 1'b1;
                st_d.vd.exact  = exact_hit;
                st_d.vd.hash   = hash_hit;
                st_d.vd.accept = exact_hit | hash_hit;
                st_d.vd.index  = step_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CNT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid  = st_q.vd.valid;
    assign dec_accept = st_q.vd.accept;
    assign dec_exact  = st_q.vd.exact;
    assign dec_hash   = st_q.vd.hash;
    assign dec_index  = st_q.vd.index;
endmodule

// File: rtl/addr_hash_filter_chk.sv
module addr_hash_filter_chk #(
    parameter int unsigned ADDR_BYTES = 6
) (
    input logic clk,
    input logic rst_n,
    input logic sof,
    input logic byte_valid,
    input logic dec_valid,
    input logic dec_accept,
    input logic dec_exact,
    input logic dec_hash
);
    localparam int unsigned CW = $clog2(ADDR_BYTES + 2);
    localparam logic [CW-1:0] FULL = CW'(ADDR_BYTES);

    // Independent byte tally per frame; saturates one past the address length.
    logic [CW-1:0] tally_q, tally_d;
    logic          armed_q;
    logic          due_q;

    always_comb begin
        tally_d = sof ? '0 : tally_q;
        if (byte_valid && (sof || armed_q) && tally_d <= FULL) tally_d = tally_d + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally_q <= '0;
            armed_q <= 1'b0;
            due_q   <= 1'b0;
        end else begin
            tally_q <= tally_d;
            armed_q <= armed_q | sof;
            due_q   <= (sof || armed_q) && byte_valid && (tally_d == FULL);
        end
    end

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    a_r6_due_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        due_q |-> dec_valid);
    a_r8_no_stray_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> due_q);
    a_r4_exact_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_exact) |-> dec_accept);
    a_r4_hash_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_hash) |-> dec_accept);
    a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);
endmodule

bind addr_hash_filter addr_hash_filter_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof        (sof),
    .byte_valid (byte_valid),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_exact  (dec_exact),
    .dec_hash   (dec_hash)
);

// File: tb/addr_hash_filter_bench.sv
module addr_hash_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [31:0] tbl_upper = '0, tbl_lower = '0, sta_upper = '0, sta_lower = '0;
    logic        dec_valid, dec_accept, dec_exact, dec_hash;
    logic [5:0]  dec_index;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;
    bit done     = 0;

    logic got_acc, got_ex, got_hs;
    logic [5:0] got_idx;

    always #2.5 clk = ~clk;

    addr_hash_filter u_addr_hash_filter (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
        .byte_data(byte_data), .tbl_upper(tbl_upper), .tbl_lower(tbl_lower),
        .sta_upper(sta_upper), .sta_lower(sta_lower), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_exact(dec_exact), .dec_hash(dec_hash),
        .dec_index(dec_index)
    );

    always @(posedge clk) if (dec_valid) pulses <= pulses + 1;

    function automatic logic [5:0] ref_index(input logic [47:0] mac);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = mac[47-8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                if (b[k] ^ c[0]) c = (c >> 1) ^ 32'hEDB88320;
                else             c = c >> 1;
            end
        end
        return c[31:26];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_station(input logic [47:0] mac, input logic [15:0] low_junk);
        sta_upper = mac[47:16];
        sta_lower = {mac[15:0], low_junk};
    endtask

    task automatic drive(input bit s, input bit v, input logic [7:0] b);
        @(negedge clk);
        sof = s; byte_valid = v; byte_data = b;
    endtask

    // Sends one address; checks pulse timing (R6) and latches the verdict.
    task automatic run_frame(input logic [47:0] mac, input bit sof_with_first);
        if (!sof_with_first) drive(1, 0, 8'h00);
        for (int i = 0; i < 6; i++) begin
            drive(sof_with_first && i == 0, 1, mac[47-8*i -: 8]);
            if (i == 5) check(dec_valid == 1'b0, "R6 early", dec_valid, 0);
        end
        drive(0, 0, 8'h00);
        check(dec_valid == 1'b1, "R6 due", dec_valid, 1);
        got_acc = dec_accept; got_ex = dec_exact; got_hs = dec_hash; got_idx = dec_index;
        @(negedge clk);
        check(dec_valid == 1'b0, "R6 one cycle", dec_valid, 0);
    endtask

    logic [47:0] mac_hi, mac_lo;

    task automatic find_macs();
        bit fh = 0, fl = 0;
        for (int x = 0; x < 256; x++) begin
            logic [47:0] m = {40'h0211223344, 8'(x)};
            if (!fh && ref_index(m) >= 32) begin mac_hi = m; fh = 1; end
            if (!fl && ref_index(m) <  32) begin mac_lo = m; fl = 1; end
        end
    endtask

    task automatic t_reset();
        int p0;
        check(dec_valid == 1'b0, "R1 reset valid", dec_valid, 0);
        p0 = pulses;
        for (int i = 0; i < 6; i++) drive(0, 1, 8'(i));
        drive(0, 0, 0);
        repeat (4) @(negedge clk);
        check(pulses == p0, "R1 bytes before sof", pulses - p0, 0);
    endtask

    task automatic t_exact();
        logic [47:0] m = 48'hA1B2C3D4E5F6;
        tbl_upper = '0; tbl_lower = '0; set_station(m, 16'h0000);
        run_frame(m, 0);
        check(got_ex == 1, "R5 exact", got_ex, 1);
        check(got_acc == 1, "R4 accept on exact", got_acc, 1);
        check(got_hs == 0, "R3 empty table", got_hs, 0);
        check(got_idx == ref_index(m), "R2 index", got_idx, ref_index(m));
    endtask

    task automatic t_hash(input logic [47:0] m);
        logic [5:0] ix = ref_index(m);
        set_station(48'h0, 16'h0);
        tbl_upper = ix >= 32 ? 32'(1) << (ix - 32) : '0;
        tbl_lower = ix <  32 ? 32'(1) << ix : '0;
        run_frame(m, 0);
        check(got_idx == ix, "R2 index", got_idx, ix);
        check(got_hs == 1 && got_acc == 1, "R3 selected bit", {got_hs, got_acc}, 2'b11);
        // Same bit number in the other word must miss.
        tbl_upper = ix <  32 ? 32'(1) << ix : '0;
        tbl_lower = ix >= 32 ? 32'(1) << (ix - 32) : '0;
        run_frame(m, 0);
        check(got_hs == 0 && got_acc == 0, "R3 wrong word", {got_hs, got_acc}, 2'b00);
        check(got_ex == 0, "R4 no exact", got_ex, 0);
    endtask

    task automatic t_station_fields();
        logic [47:0] m = 48'h0C0D0E0F1011;
        tbl_upper = '0; tbl_lower = '0; set_station(m, 16'hFFFF);
        run_frame(m, 0);
        check(got_ex == 1, "R5 low half ignored", got_ex, 1);
        set_station({m[47:8], 8'h12}, 16'h0);
        run_frame(m, 0);
        check(got_ex == 0 && got_acc == 0, "R5 byte5 mismatch", {got_ex, got_acc}, 0);
    endtask

    task automatic t_restart();
        logic [47:0] m = 48'h665544332211;
        tbl_upper = '0; tbl_lower = '0; set_station(m, 0);
        drive(1, 0, 0);
        for (int i = 0; i < 3; i++) drive(0, 1, 8'hEE);
        run_frame(m, 0);
        check(got_ex == 1 && got_idx == ref_index(m), "R7 restart", {got_ex, got_idx}, {1'b1, ref_index(m)});
        drive(1, 0, 0);
        for (int i = 0; i < 4; i++) drive(0, 1, 8'h77);
        run_frame(m, 1);
        check(got_ex == 1 && got_idx == ref_index(m), "R7 sof with byte", {got_ex, got_idx}, {1'b1, ref_index(m)});
    endtask

    task automatic t_extra();
        int p0;
        logic [47:0] m = 48'h123456789ABC;
        set_station(m, 0);
        run_frame(m, 0);
        p0 = pulses;
        for (int i = 0; i < 7; i++) drive(0, 1, 8'(i));
        drive(0, 0, 0);
        repeat (3) @(negedge clk);
        check(pulses == p0, "R8 bytes after sixth", pulses - p0, 0);
    endtask

    task automatic t_cfg();
        logic [47:0] m = 48'hDEADBEEF0102;
        tbl_upper = '0; tbl_lower = '0; set_station(m, 0);
        drive(1, 0, 0);
        drive(0, 1, m[47:40]);
        drive(0, 1, m[39:32]);
        set_station(48'h0, 0);
        for (int i = 2; i < 6; i++) drive(0, 1, m[47-8*i -: 8]);
        drive(0, 0, 0);
        check(dec_valid == 1 && dec_exact == 1, "R9 old config kept", {dec_valid, dec_exact}, 2'b11);
        run_frame(m, 0);
        check(got_ex == 0, "R9 new config next frame", got_ex, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        find_macs();
        t_reset();
        t_exact();
        t_hash(mac_hi);
        t_hash(mac_lo);
        t_station_fields();
        t_restart();
        t_extra();
        t_cfg();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule